// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. When translation is on, it reads a directory entry and then a page-table entry through one single-word memory port. It sets the accessed and dirty status bits of those entries by writing them back. If an entry is marked not present, it stops and reports a fault with the faulting address. When translation is off, the block returns the linear address unchanged and makes no memory access. Only one request is handled at a time.

A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The walk runs through the states IDLE, READ_DIR, READ_TBL, WRITEBACK, DONE and FAULT:

- IDLE goes to READ_DIR when a request is accepted with translation on, and to DONE when it is accepted with translation off.
- READ_DIR goes to FAULT, WRITEBACK or READ_TBL when its read is acknowledged.
- READ_TBL goes to FAULT, WRITEBACK or DONE when its read is acknowledged.
- WRITEBACK goes back to READ_TBL after a directory-entry write. It goes to DONE after a table-entry write.
- DONE and FAULT each last one cycle and return to IDLE.

The directory base input must be held stable while a walk runs. A separate entry-update strobe, raised by software whenever it rewrites the frame address of an entry, produces a one-cycle TLB flush pulse on its rising edge.

Top module: `ptw_walker`

## Requirements
- R1: With `paging_en` low at acceptance, `rsp_valid` is high in the cycle after acceptance with `rsp_phys_addr` equal to the linear address, and `mem_req` stays low.
- R2: With `paging_en` high, the first memory access is a read (`mem_we` low) at `dir_base + 4*lin[31:22]`.
- R3: The second read is at `{dir_entry[31:12], 12'h000} + 4*lin[21:12]`.
- R4: On success, `rsp_valid` pulses for one cycle with `rsp_phys_addr = {tbl_entry[31:12], lin[11:0]}`.
- R5: If bit 0 (present) of either entry is 0, `fault_valid` pulses for one cycle with `fault_lin_addr` equal to the linear address. In that case there is no response, no write-back of that entry and no further access.
- R6: If bit 5 (accessed) of a present entry is 0, the entry is written back to its own address with bit 5 set before the walk continues. A present entry that needs no change is not written.
- R7: On a write request, bit 6 (dirty) of the table entry is set in the write-back. Bit 6 of the directory entry is never changed.
- R8: Each rising edge of `entry_upd_strobe` gives `tlb_flush` high for exactly one cycle, one cycle later, even if the strobe stays high.
- R9: `req_ready` is high only in IDLE. A memory request holds its address, direction and data until `mem_ack`.
- R10: After reset, `req_ready` is 1 and `rsp_valid`, `fault_valid`, `mem_req` and `tlb_flush` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Translation enable, sampled at acceptance |
| dir_base | input | 32 | Byte address of the page directory |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_lin_addr | input | 32 | Linear address to translate |
| req_is_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | One-cycle pulse: translation done |
| rsp_phys_addr | output | 32 | Physical address |
| fault_valid | output | 1 | One-cycle pulse: page fault |
| fault_lin_addr | output | 32 | Linear address that faulted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Entry write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Entry read data |
| entry_upd_strobe | input | 1 | Software rewrote an entry frame address |
| tlb_flush | output | 1 | One-cycle TLB invalidate pulse |

## Verification
The hardest case to reach is a walk with two write-backs, one per level: a directory entry with accessed clear followed by a table entry that needs its accessed or dirty bit updated. That is the only path that enters WRITEBACK twice and goes back from it to READ_TBL. The bench covers this by sweeping every combination of the two present bits, the two accessed bits, the table dirty bit, the access direction and two memory latencies. Each combination uses different table addresses, computed arithmetically from the sweep index. For each one the bench predicts the exact access sequence and the final entry contents.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_DIR,
        S_READ_TBL,
        S_WRITEBACK,
        S_DONE,
        S_FAULT
    } walk_state_e;

    localparam int PRESENT_BIT  = 0;
    localparam int ACCESSED_BIT = 5;
    localparam int DIRTY_BIT    = 6;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int ADDR_W        = 32,
    parameter int OFFSET_W      = 12,
    parameter int IDX_W         = 10,
    parameter int ENTRY_SZ_LOG2 = 2
) (
    input  logic [ADDR_W-1:0]          dir_base_i,
    input  logic [IDX_W-1:0]           dir_idx_i,
    input  logic [IDX_W-1:0]           tbl_idx_i,
    input  logic [ADDR_W-OFFSET_W-1:0] tbl_frame_i,
    output logic [ADDR_W-1:0]          dir_addr_o,
    output logic [ADDR_W-1:0]          tbl_addr_o
);
    localparam int PAD_W = ADDR_W - IDX_W - ENTRY_SZ_LOG2;

    logic [ADDR_W-1:0] dir_off;
    logic [ADDR_W-1:0] tbl_off;

    // index scaled by the entry size
    assign dir_off    = {{PAD_W{1'b0}}, dir_idx_i, {ENTRY_SZ_LOG2{1'b0}}};
    assign tbl_off    = {{PAD_W{1'b0}}, tbl_idx_i, {ENTRY_SZ_LOG2{1'b0}}};
    assign dir_addr_o = dir_base_i + dir_off;
    assign tbl_addr_o = {tbl_frame_i, {OFFSET_W{1'b0}}} + tbl_off;

endmodule

// File: rtl/ptw_entry_update.sv
module ptw_entry_update
    import ptw_pkg::*;
#(
    parameter int ENTRY_W = 32
) (
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic               final_i,
    input  logic               write_i,
    output logic [ENTRY_W-1:0] entry_o,
    output logic               present_o,
    output logic               wb_o
);
    always_comb begin
        entry_o               = entry_i;
        entry_o[ACCESSED_BIT] = 1'b1;
        if (final_i && write_i) begin
            entry_o[DIRTY_BIT] = 1'b1;
        end
    end

    assign present_o = entry_i[PRESENT_BIT];
    assign wb_o      = present_o && (entry_o != entry_i);

endmodule

// File: rtl/ptw_flush_pulse.sv
module ptw_flush_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic flush_o
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            flush_o  <= 1'b0;
        end else begin
            strobe_q <= strobe_i;
            flush_o  <= strobe_i && !strobe_q;
        end
    end

    // R8: a pulse never lasts past one cycle
    p_flush_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    // R8: a new strobe edge is answered on the next cycle
    p_flush_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_i) |=> flush_o);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int OFFSET_W      = 12,
    parameter int IDX_W         = 10,
    parameter int ENTRY_SZ_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_lin_addr,
    input  logic              req_is_write,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_phys_addr,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_lin_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              entry_upd_strobe,
    output logic              tlb_flush
);
    localparam int FRAME_W = ADDR_W - OFFSET_W;
    localparam int DIR_LSB = OFFSET_W + IDX_W;
    localparam int PAD_W   = ADDR_W - IDX_W - ENTRY_SZ_LOG2;

    walk_state_e         state_q, state_d;
    logic [ADDR_W-1:0]   lin_q;
    logic                wr_q;
    logic [FRAME_W-1:0]  tbl_frame_q;
    logic [ADDR_W-1:0]   ent_addr_q;
    logic [ADDR_W-1:0]   wb_data_q;
    logic                wb_last_q;
    logic [ADDR_W-1:0]   phys_q;

    logic [ADDR_W-1:0]   dir_addr;
    logic [ADDR_W-1:0]   tbl_addr;
    logic [ADDR_W-1:0]   ent_new;
    logic                ent_present;
    logic                ent_wb;
    logic                accept;

    assign accept = (state_q == S_IDLE) && req_valid;

    ptw_entry_addr #(
        .ADDR_W        (ADDR_W),
        .OFFSET_W      (OFFSET_W),
        .IDX_W         (IDX_W),
        .ENTRY_SZ_LOG2 (ENTRY_SZ_LOG2)
    ) u_addr (
        .dir_base_i  (dir_base),
        .dir_idx_i   (lin_q[ADDR_W-1:DIR_LSB]),
        .tbl_idx_i   (lin_q[DIR_LSB-1:OFFSET_W]),
        .tbl_frame_i (tbl_frame_q),
        .dir_addr_o  (dir_addr),
        .tbl_addr_o  (tbl_addr)
    );

    ptw_entry_update #(
        .ENTRY_W (ADDR_W)
    ) u_update (
        .entry_i   (mem_rdata),
        .final_i   (state_q == S_READ_TBL),
        .write_i   (wr_q),
        .entry_o   (ent_new),
        .present_o (ent_present),
        .wb_o      (ent_wb)
    );

    ptw_flush_pulse u_flush (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (entry_upd_strobe),
        .flush_o  (tlb_flush)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) state_d = paging_en ? S_READ_DIR : S_DONE;
            end
            S_READ_DIR: begin
                if (mem_ack) begin
                    if (!ent_present)  state_d = S_FAULT;
                    else if (ent_wb)   state_d = S_WRITEBACK;
                    else               state_d = S_READ_TBL;
                end
            end
            S_READ_TBL: begin
                if (mem_ack) begin
                    if (!ent_present)  state_d = S_FAULT;
                    else if (ent_wb)   state_d = S_WRITEBACK;
                    else               state_d = S_DONE;
                end
            end
            S_WRITEBACK: begin
                if (mem_ack) state_d = wb_last_q ? S_DONE : S_READ_TBL;
            end
            S_DONE:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            lin_q       <= '0;
            wr_q        <= 1'b0;
            tbl_frame_q <= '0;
            ent_addr_q  <= '0;
            wb_data_q   <= '0;
            wb_last_q   <= 1'b0;
            phys_q      <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                lin_q  <= req_lin_addr;
                wr_q   <= req_is_write;
                phys_q <= req_lin_addr;
            end
            if (state_q == S_READ_DIR && mem_ack) begin
                tbl_frame_q <= mem_rdata[ADDR_W-1:OFFSET_W];
                ent_addr_q  <= dir_addr;
                wb_data_q   <= ent_new;
                wb_last_q   <= 1'b0;
            end
            if (state_q == S_READ_TBL && mem_ack) begin
                ent_addr_q <= tbl_addr;
                wb_data_q  <= ent_new;
                wb_last_q  <= 1'b1;
                phys_q     <= {mem_rdata[ADDR_W-1:OFFSET_W], lin_q[OFFSET_W-1:0]};
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        req_ready      = (state_q == S_IDLE);
        rsp_valid      = (state_q == S_DONE);
        rsp_phys_addr  = phys_q;
        fault_valid    = (state_q == S_FAULT);
        fault_lin_addr = lin_q;
        mem_req        = 1'b0;
        mem_we         = 1'b0;
        mem_addr       = ent_addr_q;
        mem_wdata      = wb_data_q;
        unique case (state_q)
            S_READ_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
            end
            S_READ_TBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
            end
            S_WRITEBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // R1: bypass answers on the next cycle with the untouched address
    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en) |=>
            (rsp_valid && !mem_req && rsp_phys_addr == $past(req_lin_addr)));

    // R2: a walk opens with a directory read
    p_dir_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && paging_en) |=>
            (mem_req && !mem_we && mem_addr == $past(dir_base) +
             {{PAD_W{1'b0}}, $past(req_lin_addr[ADDR_W-1:DIR_LSB]), {ENTRY_SZ_LOG2{1'b0}}}));

    // R5: a fault indication lasts one cycle and the block is idle next
    p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> (!fault_valid && req_ready));

    // R4: the response indication lasts one cycle
    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6: every write-back carries present and accessed set
    p_wb_accessed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[ACCESSED_BIT] && mem_wdata[PRESENT_BIT]));

    // R9: an unacknowledged memory request holds still
    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DIR_BASE = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b0;
    logic [31:0] dir_base = DIR_BASE;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin_addr = '0;
    logic        req_is_write = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_phys_addr;
    logic        fault_valid;
    logic [31:0] fault_lin_addr;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        entry_upd_strobe = 1'b0;
    logic        tlb_flush;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [logic [31:0]];
    int          lat = 0;
    int          wait_cnt = 0;
    logic [31:0] log_addr [8];
    logic        log_we [8];
    int          log_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker u_dut (
        .clk (clk), .rst_n (rst_n), .paging_en (paging_en), .dir_base (dir_base),
        .req_valid (req_valid), .req_ready (req_ready), .req_lin_addr (req_lin_addr),
        .req_is_write (req_is_write), .rsp_valid (rsp_valid), .rsp_phys_addr (rsp_phys_addr),
        .fault_valid (fault_valid), .fault_lin_addr (fault_lin_addr), .mem_req (mem_req),
        .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_ack (mem_ack),
        .mem_rdata (mem_rdata), .entry_upd_strobe (entry_upd_strobe), .tlb_flush (tlb_flush)
    );

    // memory model: answers after lat extra cycles, logs every completed access
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ack = 1'b1;
                if (mem_we) mem[mem_addr] = mem_wdata;
                else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                if (log_n < 8) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n]   = mem_we;
                end
                log_n++;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start_req(input logic [31:0] lin, input logic wr);
        while (!req_ready) @(negedge clk);
        log_n        = 0;
        req_valid    = 1'b1;
        req_lin_addr = lin;
        req_is_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_result(output bit got_rsp, output bit got_fault);
        got_rsp   = 1'b0;
        got_fault = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (rsp_valid || fault_valid) break;
            @(negedge clk);
        end
        got_rsp   = rsp_valid;
        got_fault = fault_valid;
        if (!got_rsp && !got_fault) check(1'b0, "R9 walk timeout", 32'h0, 32'h1);
    endtask

    task automatic run_walk(input int k);
        logic [6:0]  kb;
        logic [9:0]  di;
        logic [9:0]  ti;
        logic [11:0] off;
        logic [31:0] lin, daddr, taddr, tbase, dent, tent, exp_dent, exp_tent;
        logic [31:0] ea [4];
        logic        ew [4];
        int          en;
        bit          dp, da, tp, ta, td, wr, exp_fault, got_rsp, got_fault;

        kb   = 7'(k);
        dp   = kb[0]; da = kb[1]; tp = kb[2]; ta = kb[3]; td = kb[4]; wr = kb[5];
        lat  = int'(kb[6]);
        di   = 10'((k * 37 + 3) % 1024);
        ti   = 10'((k * 91 + 5) % 1024);
        off  = 12'((k * 13 + 7) % 4096);
        lin  = {di, ti, off};
        tbase = 32'h0020_0000 + (32'(k) << 12);
        daddr = DIR_BASE + {20'h0, di, 2'b00};
        taddr = tbase + {20'h0, ti, 2'b00};
        dent  = tbase | 32'h2 | 32'(dp) | (32'(da) << 5);
        tent  = (32'h8000_0000 + (32'(k) << 12)) | 32'h4 | 32'(tp) | (32'(ta) << 5) | (32'(td) << 6);
        mem[daddr] = dent;
        mem[taddr] = tent;

        exp_fault = !dp || !tp;
        exp_dent  = dp ? (dent | 32'h20) : dent;
        exp_tent  = (dp && tp) ? (tent | 32'h20 | (wr ? 32'h40 : 32'h0)) : tent;
        en = 0;
        ea[en] = daddr; ew[en] = 1'b0; en++;
        if (dp) begin
            if (!da) begin ea[en] = daddr; ew[en] = 1'b1; en++; end
            ea[en] = taddr; ew[en] = 1'b0; en++;
            if (tp && exp_tent != tent) begin ea[en] = taddr; ew[en] = 1'b1; en++; end
        end

        start_req(lin, wr);
        check(req_ready == 1'b0, "R9 busy during walk", 32'(req_ready), 32'h0);
        wait_result(got_rsp, got_fault);
        check(got_fault == exp_fault, "R5 fault indication", 32'(got_fault), 32'(exp_fault));
        check(got_rsp == !exp_fault, "R4 response indication", 32'(got_rsp), 32'(!exp_fault));
        if (exp_fault)
            check(fault_lin_addr == lin, "R5 fault address", fault_lin_addr, lin);
        else
            check(rsp_phys_addr == {tent[31:12], off}, "R4 physical address",
                  rsp_phys_addr, {tent[31:12], off});
        check(log_n == en, "R6 access count", 32'(log_n), 32'(en));
        for (int i = 0; i < en && i < log_n; i++) begin
            if (i == 0)
                check(log_addr[i] == ea[i] && !log_we[i], "R2 directory read",
                      log_addr[i], ea[i]);
            else if (!ew[i])
                check(log_addr[i] == ea[i] && !log_we[i], "R3 table read",
                      log_addr[i], ea[i]);
            else
                check(log_addr[i] == ea[i] && log_we[i], "R6 write-back address",
                      log_addr[i], ea[i]);
        end
        check(mem[daddr] == exp_dent, "R6 directory entry", mem[daddr], exp_dent);
        check(mem[daddr][6] == 1'b0, "R7 directory dirty untouched", 32'(mem[daddr][6]), 32'h0);
        if (wr) check(mem[taddr] == exp_tent, "R7 table entry", mem[taddr], exp_tent);
        else    check(mem[taddr] == exp_tent, "R6 table entry", mem[taddr], exp_tent);
        @(negedge clk);
        check(!rsp_valid && !fault_valid, "R5 single-cycle result",
              {30'h0, rsp_valid, fault_valid}, 32'h0);
        check(req_ready == 1'b1, "R9 idle after result", 32'(req_ready), 32'h1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10 reset values
        check(req_ready == 1'b1, "R10 ready in reset", 32'(req_ready), 32'h1);
        check(!rsp_valid && !fault_valid && !mem_req && !tlb_flush, "R10 outputs low in reset",
              {28'h0, rsp_valid, fault_valid, mem_req, tlb_flush}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !mem_req, "R10 ready after reset",
              {30'h0, req_ready, mem_req}, 32'h2);

        // R1 bypass sweep
        paging_en = 1'b0;
        for (int j = 0; j < 16; j++) begin
            logic [31:0] lin;
            lin = 32'(j) * 32'h1357_9BDF + 32'h0F0F_0001;
            start_req(lin, j[0]);
            check(rsp_valid == 1'b1, "R1 bypass latency", 32'(rsp_valid), 32'h1);
            check(rsp_phys_addr == lin, "R1 bypass address", rsp_phys_addr, lin);
            @(negedge clk);
            check(log_n == 0 && !mem_req, "R1 no memory access", 32'(log_n), 32'h0);
        end

        // walks: all present/accessed/dirty/direction/latency combinations
        paging_en = 1'b1;
        for (int k = 0; k < 128; k++) run_walk(k);

        // R8 flush pulse shaping
        entry_upd_strobe = 1'b1;
        @(negedge clk);
        check(tlb_flush == 1'b1, "R8 flush on strobe edge", 32'(tlb_flush), 32'h1);
        @(negedge clk);
        check(tlb_flush == 1'b0, "R8 flush lasts one cycle", 32'(tlb_flush), 32'h0);
        @(negedge clk);
        check(tlb_flush == 1'b0, "R8 held strobe gives no repeat", 32'(tlb_flush), 32'h0);
        entry_upd_strobe = 1'b0;
        @(negedge clk);
        check(tlb_flush == 1'b0, "R8 no flush on falling edge", 32'(tlb_flush), 32'h0);
        entry_upd_strobe = 1'b1;
        @(negedge clk);
        entry_upd_strobe = 1'b0;
        check(tlb_flush == 1'b1, "R8 flush on second edge", 32'(tlb_flush), 32'h1);
        @(negedge clk);
        check(tlb_flush == 1'b0, "R8 second pulse one cycle", 32'(tlb_flush), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule